// File: doc/BRIEF.md
# Data ROM Port Address Sequencer

This block lets a host processor pull a stream of bytes out of a large data ROM through a single read port, without reloading an address for every byte. The host loads a 24-bit base pointer, a 16-bit offset, a 16-bit step and a mode byte through byte-wide register writes. It then issues read requests on one of two ports. Each request fetches one byte from a synchronous ROM and can move the pointer state for the next request.

The primary port fetches at the base or at base plus offset. It then advances the base or the offset by one or by the step value. The secondary port always fetches at base plus offset and can then apply a follow-up adjustment. Offset writes can also move the base immediately, once both offset bytes have been written. The mode byte chooses which of these happens and whether offset and step are treated as signed. Every ROM address and every recomputed base is reduced modulo the ROM size parameter.

Top module: `rom_stream_seq`

## Requirements
- R1: After reset, all eight registers read 0, the written-tracking state is empty and `dataValid` is 0.
- R2: A write with `wrAddr` code 0/1/2 loads base bits 7:0/15:8/23:16, code 3/4 loads offset bits 7:0/15:8, code 5/6 loads step bits 7:0/15:8 and code 7 loads the mode byte. Reading with the same code on `regSel` returns the last written or updated value.
- R3: A primary request made before all three base bytes have been written since reset does not pulse `romEn`. It returns 0 and leaves every register unchanged.
- R4: A request accepted in cycle t drives `romEn` and `romAddr` in cycle t. In cycle t+1 it raises `dataValid` with the fetched byte on `dataOut`, and register updates are visible from t+1. A request made in a cycle with `wrEn` high is dropped. When both ports request together, only the primary is served.
- R5: With mode bit 1 set, the primary port fetches at base plus offset, where mode bit 3 set means a signed offset. It then adds 1 to the offset, wrapping 0xFFFF to 0, and leaves the base unchanged.
- R6: With mode bit 1 clear, the primary port fetches at the base. The step is 1 if mode bit 0 is clear. Otherwise it is the step register, treated as signed when mode bit 2 is set.
- R7: With mode bit 1 clear, mode bit 4 clear adds the step to the base. Mode bit 4 set adds the step to the offset (16-bit wrap) and leaves the base unchanged.
- R8: Every ROM address and every recomputed base is the 24-bit wrapped sum reduced modulo `ROM_SIZE`.
- R9: The secondary port is served only after all three base bytes and both offset bytes have been written. Otherwise it returns 0 with no state change. When served, it fetches at base plus offset, with the sign set by mode bit 3.
- R10: After a secondary fetch with mode bits 5 and 6 both set, mode bit 4 clear adds the offset to the base and mode bit 4 set doubles the offset. Other modes change nothing.
- R11: With mode bit 1 set and exactly one of mode bits 5 and 6 set, writing both offset bytes in either order moves the base, provided mode bit 4 is clear. The amount is the new low offset byte under bit 5, or the new 16-bit offset under bit 6, signed when mode bit 3 is set. The moved base is visible after the completing write.
- R12: The offset-byte tracker of R11 empties when the mode register is written and when it completes. Offset writes made while the R11 condition is false are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register code for the write |
| wrData | input | 8 | Write data byte |
| regSel | input | 3 | Register code for readback |
| regData | output | 8 | Readback byte (combinational) |
| priRd | input | 1 | Primary port read request |
| auxRd | input | 1 | Secondary port read request |
| romEn | output | 1 | ROM read enable |
| romAddr | output | ROM_AW | ROM byte address |
| romData | input | 8 | ROM data, valid the cycle after `romEn` |
| dataOut | output | 8 | Returned byte |
| dataValid | output | 1 | Returned byte is valid |

## Verification
The bench targets the offset wrap at 0xFFFF, which a design with a wider counter would carry into bit 16. It also targets the base reaching exactly `ROM_SIZE` or overflowing 24 bits, where a missing reduction would drive addresses off the end of the ROM. Signed steps and offsets with bit 15 or bit 7 set are applied, so zero-extension shows up as large forward jumps. The offset tracker is driven through its traps: a mode rewrite between the two offset bytes, the opposite write order, and mode bit 4 blocking the move. A design that fired early or twice would show a moved base at readback.

// File: rtl/romseq_pkg.sv
package romseq_pkg;
  localparam int REG_N = 8;
  localparam int IDX_BASE0 = 0;
  localparam int IDX_BASE1 = 1;
  localparam int IDX_BASE2 = 2;
  localparam int IDX_OFS0 = 3;
  localparam int IDX_OFS1 = 4;
  localparam int IDX_STEP0 = 5;
  localparam int IDX_STEP1 = 6;
  localparam int IDX_MODE = 7;
  localparam int MB_STEPREG = 0;
  localparam int MB_OFSREAD = 1;
  localparam int MB_STEPSGN = 2;
  localparam int MB_OFSSGN = 3;
  localparam int MB_TOOFS = 4;
  localparam int MB_ADJ8 = 5;
  localparam int MB_ADJ16 = 6;

  typedef struct packed {
    logic [REG_N-1:0] ld;
    logic priGo;
    logic auxGo;
    logic immGo;
  } seqStb_t;

  function automatic logic [23:0] ext16(input logic [15:0] v, input logic sgn);
    return sgn ? {{8{v[15]}}, v} : {8'h00, v};
  endfunction

  function automatic logic [23:0] ext8(input logic [7:0] v, input logic sgn);
    return sgn ? {{16{v[7]}}, v} : {16'h0000, v};
  endfunction
endpackage

// File: rtl/romseq_ctrl.sv
module romseq_ctrl
  import romseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [2:0]  wrAddr,
  input  logic        priRd,
  input  logic        auxRd,
  input  logic [7:0]  mode,
  output seqStb_t     stb,
  output logic        romEn,
  output logic        validQ,
  output logic        zeroQ
);
  logic [4:0] mask;
  logic [1:0] trk;
  logic [1:0] trkSum;
  logic       priAcc, auxAcc, baseAll, maskFull, immArm, immFire;
  logic       unusedMode;

  assign unusedMode = ^{mode[7], mode[3], mode[2], mode[0]};

  always_comb begin
    for (int i = 0; i < REG_N; i++) stb.ld[i] = wrEn && (wrAddr == 3'(i));
  end

  assign priAcc   = priRd && !wrEn;
  assign auxAcc   = auxRd && !priRd && !wrEn;
  assign baseAll  = &mask[2:0];
  assign maskFull = &mask;
  assign immArm   = mode[MB_OFSREAD] && (mode[MB_ADJ8] ^ mode[MB_ADJ16]);
  assign trkSum   = trk | ({stb.ld[IDX_OFS1], stb.ld[IDX_OFS0]} & {2{immArm}});
  assign immFire  = (trkSum == 2'b11);

  assign stb.priGo = priAcc && baseAll;
  assign stb.auxGo = auxAcc && maskFull;
  assign stb.immGo = immFire && !mode[MB_TOOFS];
  assign romEn     = stb.priGo || stb.auxGo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mask   <= '0;
      trk    <= '0;
      validQ <= 1'b0;
      zeroQ  <= 1'b0;
    end else begin
      mask   <= mask | stb.ld[4:0];
      if (stb.ld[IDX_MODE] || immFire) trk <= '0;
      else                              trk <= trkSum;
      validQ <= priAcc || auxAcc;
      zeroQ  <= (priAcc && !baseAll) || (auxAcc && !maskFull);
    end
  end

  // R12
  trk_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ld[IDX_MODE] |=> (trk == 2'b00));

  // R4
  req_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((priRd || auxRd) && !wrEn) |=> validQ);

  // R3
  blocked_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (priRd && !wrEn && !(&mask[2:0])) |=> (validQ && zeroQ));
endmodule

// File: rtl/romseq_dp.sv
module romseq_dp
  import romseq_pkg::*;
#(
  parameter int ROM_SIZE = 786432,
  localparam int ROM_AW = $clog2(ROM_SIZE)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStb_t           stb,
  input  logic [7:0]        wrData,
  input  logic [2:0]        regSel,
  output logic [7:0]        regData,
  output logic [7:0]        mode,
  output logic [ROM_AW-1:0] romAddr
);
  localparam logic [23:0] SIZE24 = 24'(ROM_SIZE);

  logic [23:0] base;
  logic [15:0] ofs, step;
  logic [23:0] ofsExt, stepExt, ofsSum, addrFull, immAmt;
  logic [15:0] newOfs;
  logic        adjBoth, unusedBits;

  function automatic logic [23:0] sizeMod(input logic [23:0] x);
    return x % SIZE24;
  endfunction

  assign ofsExt  = ext16(ofs, mode[MB_OFSSGN]);
  assign stepExt = mode[MB_STEPREG] ? ext16(step, mode[MB_STEPSGN]) : 24'd1;
  assign ofsSum  = base + ofsExt;
  assign adjBoth = mode[MB_ADJ8] && mode[MB_ADJ16];

  assign addrFull = (stb.auxGo || mode[MB_OFSREAD]) ? sizeMod(ofsSum) : sizeMod(base);
  assign romAddr  = addrFull[ROM_AW-1:0];
  assign unusedBits = ^{addrFull[23:ROM_AW], mode[7]};

  assign newOfs = {stb.ld[IDX_OFS1] ? wrData : ofs[15:8],
                   stb.ld[IDX_OFS0] ? wrData : ofs[7:0]};
  assign immAmt = mode[MB_ADJ8] ? ext8(newOfs[7:0], mode[MB_OFSSGN])
                                : ext16(newOfs, mode[MB_OFSSGN]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      base <= '0;
      ofs  <= '0;
      step <= '0;
      mode <= '0;
    end else begin
      if (stb.ld[IDX_BASE0] || stb.ld[IDX_BASE1] || stb.ld[IDX_BASE2]) begin
        for (int b = 0; b < 3; b++)
          if (stb.ld[IDX_BASE0 + b]) base[8*b +: 8] <= wrData;
      end else if (stb.immGo) begin
        base <= sizeMod(base + immAmt);
      end else if (stb.priGo && !mode[MB_OFSREAD] && !mode[MB_TOOFS]) begin
        base <= sizeMod(base + stepExt);
      end else if (stb.auxGo && adjBoth && !mode[MB_TOOFS]) begin
        base <= sizeMod(ofsSum);
      end

      if (stb.ld[IDX_OFS0] || stb.ld[IDX_OFS1]) begin
        ofs <= newOfs;
      end else if (stb.priGo) begin
        if (mode[MB_OFSREAD])     ofs <= ofs + 16'd1;
        else if (mode[MB_TOOFS])  ofs <= ofs + stepExt[15:0];
      end else if (stb.auxGo && adjBoth && mode[MB_TOOFS]) begin
        ofs <= {ofs[14:0], 1'b0};
      end

      if (stb.ld[IDX_STEP0]) step[7:0]  <= wrData;
      if (stb.ld[IDX_STEP1]) step[15:8] <= wrData;
      if (stb.ld[IDX_MODE])  mode       <= wrData;
    end
  end

  always_comb begin
    unique case (regSel)
      3'd0: regData = base[7:0];
      3'd1: regData = base[15:8];
      3'd2: regData = base[23:16];
      3'd3: regData = ofs[7:0];
      3'd4: regData = ofs[15:8];
      3'd5: regData = step[7:0];
      3'd6: regData = step[15:8];
      default: regData = mode;
    endcase
  end

  // R8
  addr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.priGo || stb.auxGo) |-> (24'(romAddr) < SIZE24));

  // R8
  base_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.immGo || (stb.priGo && !mode[MB_OFSREAD] && !mode[MB_TOOFS])) |=> (base < SIZE24));

  // R5
  ofs_read_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.priGo && mode[MB_OFSREAD]) |=> $stable(base));

  // R7
  to_ofs_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.priGo && !mode[MB_OFSREAD] && mode[MB_TOOFS]) |=> $stable(base));
endmodule

// File: rtl/rom_stream_seq.sv
module rom_stream_seq
  import romseq_pkg::*;
#(
  parameter int ROM_SIZE = 786432,
  localparam int ROM_AW = $clog2(ROM_SIZE)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [7:0]        wrData,
  input  logic [2:0]        regSel,
  output logic [7:0]        regData,
  input  logic              priRd,
  input  logic              auxRd,
  output logic              romEn,
  output logic [ROM_AW-1:0] romAddr,
  input  logic [7:0]        romData,
  output logic [7:0]        dataOut,
  output logic              dataValid
);
  seqStb_t    stb;
  logic [7:0] mode;
  logic       validQ, zeroQ;

  romseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .priRd(priRd), .auxRd(auxRd), .mode(mode), .stb(stb),
    .romEn(romEn), .validQ(validQ), .zeroQ(zeroQ)
  );

  romseq_dp #(.ROM_SIZE(ROM_SIZE)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .regSel(regSel), .regData(regData), .mode(mode), .romAddr(romAddr)
  );

  assign dataOut   = zeroQ ? 8'h00 : romData;
  assign dataValid = validQ;

  // R4
  single_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.priGo, stb.auxGo, wrEn}));
endmodule

// File: tb/sim_rom_stream_seq.sv
`timescale 1ns/100ps
module sim_rom_stream_seq;
  localparam int SZ = 786432;
  localparam int AW = 20;

  logic clk = 0, rstN = 0;
  logic wrEn = 0, priRd = 0, auxRd = 0;
  logic [2:0] wrAddr = 0, regSel = 0;
  logic [7:0] wrData = 0, romData = 0;
  logic [7:0] regData, dataOut;
  logic romEn, dataValid;
  logic [AW-1:0] romAddr;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [23:0] mBase;
  logic [15:0] mOff, mStep;
  logic [7:0]  mMode;
  logic [4:0]  mMask;
  logic [1:0]  mTrk;

  rom_stream_seq #(.ROM_SIZE(SZ)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .regSel(regSel), .regData(regData), .priRd(priRd), .auxRd(auxRd),
    .romEn(romEn), .romAddr(romAddr), .romData(romData),
    .dataOut(dataOut), .dataValid(dataValid)
  );

  always #2.5 clk = ~clk;

  function automatic logic [7:0] romf(input logic [AW-1:0] a);
    logic [31:0] t;
    t = (32'(a) * 32'd37) ^ (32'(a) >> 11);
    return t[7:0];
  endfunction

  always @(posedge clk) if (romEn) romData <= romf(romAddr);

  function automatic logic [23:0] mmod(input logic [23:0] x);
    return x % 24'(SZ);
  endfunction
  function automatic logic [23:0] x16(input logic [15:0] v, input logic s);
    return s ? {{8{v[15]}}, v} : {8'h00, v};
  endfunction
  function automatic logic [23:0] x8(input logic [7:0] v, input logic s);
    return s ? {{16{v[7]}}, v} : {16'h0000, v};
  endfunction
  function automatic logic [7:0] mreg(input int i);
    case (i)
      0: return mBase[7:0];
      1: return mBase[15:8];
      2: return mBase[23:16];
      3: return mOff[7:0];
      4: return mOff[15:8];
      5: return mStep[7:0];
      6: return mStep[15:8];
      default: return mMode;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic chkRegs(input string tag);
    for (int i = 0; i < 8; i++) begin
      regSel = 3'(i);
      #0.2;
      chk(tag, 32'(regData), 32'(mreg(i)));
    end
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    logic arm;
    arm = mMode[1] && (mMode[5] ^ mMode[6]);
    wrEn = 1; wrAddr = 3'(a); wrData = d;
    @(negedge clk);
    wrEn = 0;
    case (a)
      0: mBase[7:0] = d;
      1: mBase[15:8] = d;
      2: mBase[23:16] = d;
      3: mOff[7:0] = d;
      4: mOff[15:8] = d;
      5: mStep[7:0] = d;
      6: mStep[15:8] = d;
      default: mMode = d;
    endcase
    if (a < 5) mMask[a] = 1'b1;
    if (a == 7) mTrk = 0;
    else if ((a == 3 || a == 4) && arm) begin
      mTrk = mTrk | ((a == 3) ? 2'b01 : 2'b10);
      if (mTrk == 2'b11) begin
        mTrk = 0;
        if (!mMode[4])
          mBase = mmod(mBase + (mMode[5] ? x8(mOff[7:0], mMode[3]) : x16(mOff, mMode[3])));
      end
    end
  endtask

  task automatic pri(input string tag);
    logic blk;
    logic [23:0] a, st;
    logic [7:0] e;
    blk = (mMask[2:0] != 3'b111);
    a = mMode[1] ? mmod(mBase + x16(mOff, mMode[3])) : mmod(mBase);
    e = blk ? 8'h00 : romf(a[AW-1:0]);
    priRd = 1;
    #1;
    chk(tag, 32'(romEn), 32'(!blk));
    if (!blk) begin
      chk(tag, 32'(romAddr), 32'(a));
      if (mMode[1]) mOff = mOff + 16'd1;
      else begin
        st = mMode[0] ? x16(mStep, mMode[2]) : 24'd1;
        if (mMode[4]) mOff = mOff + st[15:0];
        else mBase = mmod(mBase + st);
      end
    end
    @(negedge clk);
    priRd = 0;
    #0.1;
    chk(tag, 32'(dataValid), 1);
    chk(tag, 32'(dataOut), 32'(e));
    chkRegs(tag);
  endtask

  task automatic aux(input string tag);
    logic blk;
    logic [23:0] a;
    logic [7:0] e;
    blk = (mMask != 5'h1F);
    a = mmod(mBase + x16(mOff, mMode[3]));
    e = blk ? 8'h00 : romf(a[AW-1:0]);
    auxRd = 1;
    #1;
    chk(tag, 32'(romEn), 32'(!blk));
    if (!blk) begin
      chk(tag, 32'(romAddr), 32'(a));
      if (mMode[5] && mMode[6]) begin
        if (mMode[4]) mOff = {mOff[14:0], 1'b0};
        else mBase = mmod(mBase + x16(mOff, mMode[3]));
      end
    end
    @(negedge clk);
    auxRd = 0;
    #0.1;
    chk(tag, 32'(dataValid), 1);
    chk(tag, 32'(dataOut), 32'(e));
    chkRegs(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    mBase = 0; mOff = 0; mStep = 0; mMode = 0; mMask = 0; mTrk = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 valid", 32'(dataValid), 0);
    chkRegs("R1");

    pri("R3 none written");
    wr(0, 8'h12); wr(1, 8'h34);
    pri("R3 two bytes");
    wr(2, 8'h05);
    aux("R9 offset unwritten");
    pri("R6 step one");
    pri("R6 step one again");
    wr(5, 8'hFE); wr(6, 8'hFF); wr(7, 8'h05);
    pri("R6 signed step");
    wr(7, 8'h01);
    pri("R6 unsigned step");
    wr(7, 8'h10);
    pri("R7 step to offset");
    wr(7, 8'h02); wr(3, 8'hFF); wr(4, 8'hFF);
    chkRegs("R2 readback");
    pri("R5 offset wrap");
    wr(7, 8'h0A); wr(3, 8'h00); wr(4, 8'h80);
    pri("R5 signed offset");
    wr(7, 8'h00); wr(0, 8'hFF); wr(1, 8'hFF); wr(2, 8'h0B);
    pri("R8 base at size minus one");
    wr(0, 8'hFF); wr(1, 8'hFF); wr(2, 8'hFF);
    pri("R8 base above size");
    wr(4, 8'h01); wr(3, 8'h20); wr(7, 8'h60);
    aux("R10 add offset");
    wr(7, 8'h70);
    aux("R10 double offset");
    wr(7, 8'h40);
    aux("R10 no adjust");
    wr(7, 8'h22); wr(3, 8'hF0); wr(4, 8'h00);
    chkRegs("R11 low byte move");
    wr(7, 8'h2A); wr(4, 8'h00); wr(3, 8'hF0);
    chkRegs("R11 signed low byte");
    wr(7, 8'h42); wr(4, 8'h12); wr(3, 8'h34);
    chkRegs("R11 full offset");
    wr(7, 8'h32); wr(3, 8'h11); wr(4, 8'h22);
    chkRegs("R11 blocked by bit4");
    wr(7, 8'h22); wr(3, 8'h05); wr(7, 8'h22); wr(4, 8'h00);
    chkRegs("R12 mode write clears");
    wr(3, 8'h07);
    chkRegs("R12 completes later");
    wr(7, 8'h02); wr(3, 8'h01); wr(7, 8'h22); wr(4, 8'h00);
    chkRegs("R12 unarmed write ignored");

    // R4: simultaneous requests, primary wins; request during a write is dropped
    wr(7, 8'h00);
    begin
      logic [23:0] a0;
      a0 = mmod(mBase);
      priRd = 1; auxRd = 1; #1;
      chk("R4 both ports addr", 32'(romAddr), 32'(a0));
      @(negedge clk); priRd = 0; auxRd = 0; #0.1;
      chk("R4 both ports data", 32'(dataOut), 32'(romf(a0[AW-1:0])));
      mBase = mmod(mBase + 24'd1);
      chkRegs("R4 both ports state");
      wrEn = 1; wrAddr = 3'd5; wrData = 8'h33; priRd = 1; #1;
      chk("R4 dropped romEn", 32'(romEn), 0);
      @(negedge clk); wrEn = 0; priRd = 0; mStep[7:0] = 8'h33; #0.1;
      chk("R4 dropped valid", 32'(dataValid), 0);
      chkRegs("R4 dropped state");
    end

    for (int n = 0; n < 900; n++) begin
      int op;
      op = int'($urandom % 10);
      if (op < 4) begin
        int a;
        logic [7:0] d;
        a = int'($urandom % 8);
        d = 8'($urandom);
        if (a == 2 && ($urandom % 2) == 1) d = 8'h0B;
        wr(a, d);
      end else if (op < 7) pri(mMode[1] ? "R5 random" : (mMode[4] ? "R7 random" : "R6 random"));
      else if (op < 9) aux("R10 random");
      else chkRegs("R11 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule